// File: doc/BRIEF.md
# Level Interrupt Aggregator with Identification Words

This peripheral gathers up to sixteen level-sensitive interrupt requests and presents them to a host processor as a single active-low, level-sensitive interrupt line. Each request passes through a two-flop synchroniser and then sets a sticky status bit. Software reads the status word, masks sources it does not want, and clears serviced bits through a dedicated clear register.

The clear register uses a pulse that software holds. Writing a 1 to a bit of the clear register holds the matching status bit at zero. Writing 0 afterwards releases the clear. If the source is still active at that point, the bit sets again. The mask uses set-to-disable polarity: a 1 blocks a source.

Three constant identification words and a parameter-set version word let software confirm that the hardware is present before it enables anything. Accesses use a simple synchronous strobe bus: chip select, read and write strobes, a byte address and 16-bit data. Read data is combinational from the current strobes and address.

Top module: `irq_expander`

## Requirements
- R1: After reset, status reads 0x0000, mask reads 0xFFFF, clear reads 0x0000 and `irq_no` is high.
- R2: A source held high sets its status bit after the third rising clock edge that samples it high. That is two synchroniser stages plus the status flop.
- R3: A set status bit stays set after its source returns low, until it is cleared.
- R4: `irq_no` is low exactly when (status AND NOT mask) is nonzero. A mask bit of 1 disables its source and 0 enables it.
- R5: Writing 1 to a bit of the clear register at byte offset 0x20 holds that status bit at 0 while the clear bit stays 1. The clear register reads back its held value.
- R6: When a clear bit is released by writing 0 while the source is still high, the status bit sets again one edge after the release write.
- R7: Byte offset 0x40 reads 0xAAAA, 0x48 reads 0x5555, 0x58 reads 0xCAFE and 0x50 reads the VERSION parameter.
- R8: Writes to offsets other than 0x20 and 0x38 change no register. Reads of unmapped offsets, including odd offsets, return 0. `rdata_o` is 0 whenever `cs_i` and `rd_i` are not both high.
- R9: The mask register at byte offset 0x38 is written with `wdata_i` and reads back the written value. For example, 0x001F disables sources 0 to 4. The status register reads at offset 0x10, with bit i belonging to source i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select for this register window |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte offset within the window |
| wdata_i | input | 16 | Write data |
| src_i | input | NSRC | Level interrupt requests, active high |
| rdata_o | output | 16 | Read data, zero when not reading |
| irq_no | output | 1 | Combined interrupt to host, active low |

## Verification
The bench targets the synchroniser latency. A design with one stage too few or too many would show status one edge early or late against the reference.

It checks that the clear wins over a still-active source while held and that the bit then returns after release. A design that cleared on an edge or ignored the hold would leave the bit set, or lose it for good.

It checks mask polarity and the combined output with several patterns, where an inverted mask would drive `irq_no` the wrong way.

It writes to status and ID offsets and reads odd and unmapped addresses. A loose address decode would then corrupt a register or return stale data.

// File: rtl/irq_exp_pkg.sv
package irq_exp_pkg;
  localparam int REG_W = 16;

  localparam int OFS_STATUS = 'h10;
  localparam int OFS_CLEAR  = 'h20;
  localparam int OFS_MASK   = 'h38;
  localparam int OFS_ID_A   = 'h40;
  localparam int OFS_ID_B   = 'h48;
  localparam int OFS_VER    = 'h50;
  localparam int OFS_ID_C   = 'h58;

  localparam logic [REG_W-1:0] ID_A_WORD = 16'hAAAA;
  localparam logic [REG_W-1:0] ID_B_WORD = 16'h5555;
  localparam logic [REG_W-1:0] ID_C_WORD = 16'hCAFE;
endpackage

// File: rtl/irq_exp_sync.sv
module irq_exp_sync #(
  parameter int NSRC   = 16,
  parameter int STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] d_i,
  output logic [NSRC-1:0] q_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/irq_exp_regs.sv
module irq_exp_regs
  import irq_exp_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   clr_o
);
  logic hit_mask, hit_clr;
  assign hit_mask = wr_en_i && (addr_i == ADDR_W'(OFS_MASK));
  assign hit_clr  = wr_en_i && (addr_i == ADDR_W'(OFS_CLEAR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      clr_o  <= '0;
    end else begin
      if (hit_mask) mask_o <= wdata_i[NSRC-1:0];
      if (hit_clr)  clr_o  <= wdata_i[NSRC-1:0];
    end
  end
endmodule

// File: rtl/irq_exp_status.sv
module irq_exp_status #(
  parameter int NSRC = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] st_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_st
    // held clear dominates a live request
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       st_o[i] <= 1'b0;
      else if (clr_i[i]) st_o[i] <= 1'b0;
      else if (req_i[i]) st_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_expander.sv
module irq_expander
  import irq_exp_pkg::*;
#(
  parameter int          NSRC    = 16,
  parameter int          ADDR_W  = 8,
  parameter logic [15:0] VERSION = 16'h0102
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [NSRC-1:0]   src_i,
  output logic [15:0]       rdata_o,
  output logic              irq_no
);
  logic [NSRC-1:0] sync_w, status_w, mask_w, clr_w;
  logic [REG_W-1:0] st_ext, mask_ext, clr_ext;

  irq_exp_sync #(.NSRC(NSRC), .STAGES(2)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(src_i), .q_o(sync_w)
  );

  irq_exp_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(cs_i && wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .mask_o (mask_w),
    .clr_o  (clr_w)
  );

  irq_exp_status #(.NSRC(NSRC)) u_status (
    .clk_i (clk_i), .rst_ni(rst_ni), .req_i(sync_w), .clr_i(clr_w), .st_o(status_w)
  );

  always_comb begin
    st_ext   = '0;
    mask_ext = '0;
    clr_ext  = '0;
    st_ext[NSRC-1:0]   = status_w;
    mask_ext[NSRC-1:0] = mask_w;
    clr_ext[NSRC-1:0]  = clr_w;
  end

  always_comb begin
    rdata_o = '0;
    if (cs_i && rd_i) begin
      case (int'(addr_i))
        OFS_STATUS: rdata_o = st_ext;
        OFS_CLEAR:  rdata_o = clr_ext;
        OFS_MASK:   rdata_o = mask_ext;
        OFS_ID_A:   rdata_o = ID_A_WORD;
        OFS_ID_B:   rdata_o = ID_B_WORD;
        OFS_VER:    rdata_o = VERSION;
        OFS_ID_C:   rdata_o = ID_C_WORD;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign irq_no = ~|(status_w & ~mask_w);
endmodule

// File: rtl/irq_expander_chk.sv
module irq_expander_chk
  import irq_exp_pkg::*;
#(
  parameter int NSRC   = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       rdata_o,
  input logic              irq_no,
  input logic [NSRC-1:0]   sync_w,
  input logic [NSRC-1:0]   status_w,
  input logic [NSRC-1:0]   mask_w,
  input logic [NSRC-1:0]   clr_w
);
  // R2: a status bit only rises where the synchroniser output was high
  a_r2_set_from_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_w & ~$past(status_w) & ~$past(sync_w)) == '0));

  // R3: set bits with no held clear survive
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_w) & ~$past(clr_w)) & ~status_w) == '0));

  // R5: a held clear forces the bit low on the next edge
  a_r5_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_w) |=> ((status_w & $past(clr_w)) == '0));

  // R4: fully masked or empty status keeps the host line idle
  a_r4_masked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_w & ~mask_w) == '0) |-> irq_no);

  // R8: no read strobe, no data
  a_r8_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> (rdata_o == '0));

  // R8: writes away from the mask offset leave the mask alone
  a_r8_mask_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(cs_i && wr_i) || addr_i != ADDR_W'(OFS_MASK)) |=> $stable(mask_w));

  // R7: identification constant
  a_r7_id_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == ADDR_W'(OFS_ID_C)) |-> (rdata_o == ID_C_WORD));
endmodule

bind irq_expander irq_expander_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_no  (irq_no),
  .sync_w  (sync_w),
  .status_w(status_w),
  .mask_w  (mask_w),
  .clr_w   (clr_w)
);

// File: tb/irq_expander_bench.sv
module irq_expander_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] VER        = 16'h0317;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] src_i = '0;
  logic [15:0] rdata_o;
  logic        irq_no;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // reference state
  logic [15:0] m_st = '0, m_mask = 16'hFFFF, m_clr = '0;
  logic [15:0] m_hist[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_expander #(.NSRC(16), .ADDR_W(8), .VERSION(VER)) u_irq_expander (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .src_i(src_i),
    .rdata_o(rdata_o), .irq_no(irq_no)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = '0; m_mask = 16'hFFFF; m_clr = '0; m_hist.delete();
    end else begin
      logic [15:0] seen;
      seen = (m_hist.size() >= 2) ? m_hist[m_hist.size()-2] : 16'h0;
      m_st = (m_st | seen) & ~m_clr;
      if (cs_i && wr_i && addr_i == 8'h38) m_mask = wdata_i;
      if (cs_i && wr_i && addr_i == 8'h20) m_clr  = wdata_i;
      m_hist.push_back(src_i);
      if (m_hist.size() > 2) void'(m_hist.pop_front());
    end
  end

  function automatic logic [15:0] exp_rdata();
    if (!(cs_i && rd_i)) return 16'h0;
    case (addr_i)
      8'h10: return m_st;
      8'h20: return m_clr;
      8'h38: return m_mask;
      8'h40: return 16'hAAAA;
      8'h48: return 16'h5555;
      8'h50: return VER;
      8'h58: return 16'hCAFE;
      default: return 16'h0;
    endcase
  endfunction

  task automatic compare();
    logic [15:0] er;
    logic        ei;
    er = exp_rdata();
    ei = ((m_st & ~m_mask) == 16'h0);
    n_vec++;
    if (rdata_o !== er) begin
      n_bad++;
      $display("FAIL %s rdata addr=%h got %h exp %h", cur_req, addr_i, rdata_o, er);
    end
    n_vec++;
    if (irq_no !== ei) begin
      n_bad++;
      $display("FAIL %s irq_no got %b exp %b", cur_req, irq_no, ei);
    end
  endtask

  task automatic cyc(input logic c, input logic r, input logic w,
                     input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    cs_i = c; rd_i = r; wr_i = w; addr_i = a; wdata_i = d;
    #1 compare();
  endtask

  task automatic rd(input logic [7:0] a);
    cyc(1'b1, 1'b1, 1'b0, a, 16'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    cyc(1'b1, 1'b0, 1'b1, a, d);
  endtask

  task automatic poll(input int n);
    for (int k = 0; k < n; k++) rd(8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    cur_req = "R1";
    rd(8'h10); rd(8'h38); rd(8'h20);

    cur_req = "R7";
    rd(8'h40); rd(8'h48); rd(8'h50); rd(8'h58);

    cur_req = "R9";
    wr(8'h38, 16'hFFFE); rd(8'h38);

    cur_req = "R2";
    @(negedge clk_i); src_i = 16'h0001;
    poll(5);

    cur_req = "R3";
    src_i = 16'h0000;
    poll(4);

    cur_req = "R4";
    wr(8'h38, 16'hFFFF); poll(2);
    wr(8'h38, 16'h0000); poll(2);
    wr(8'h38, 16'h0001); poll(2);

    cur_req = "R5";
    wr(8'h20, 16'h0001); rd(8'h20); poll(3);
    wr(8'h20, 16'h0000); poll(3);

    cur_req = "R6";
    wr(8'h38, 16'h0000);
    src_i = 16'h0008; poll(4);
    wr(8'h20, 16'h0008); poll(3);
    wr(8'h20, 16'h0000); poll(3);
    src_i = 16'h0000; poll(3);
    wr(8'h20, 16'h0008); wr(8'h20, 16'h0000); poll(3);

    cur_req = "R8";
    src_i = 16'h0040; poll(4);
    wr(8'h10, 16'hFFFF); rd(8'h10);
    wr(8'h40, 16'h1234); rd(8'h40);
    wr(8'h30, 16'hFFFF); rd(8'h38);
    wr(8'h39, 16'hFFFF); rd(8'h38);
    rd(8'h11); rd(8'h12); rd(8'h39); rd(8'h21); rd(8'hFF);
    cyc(1'b0, 1'b1, 1'b0, 8'h40, 16'h0);
    cyc(1'b1, 1'b0, 1'b0, 8'h58, 16'h0);
    src_i = 16'h0000;

    cur_req = "R9";
    wr(8'h20, 16'hFFFF); wr(8'h20, 16'h0000);
    wr(8'h38, 16'h001F); rd(8'h38);
    src_i = 16'h000C; poll(5);
    src_i = 16'hA5A0; poll(5);
    src_i = 16'h0000;
    wr(8'h38, 16'h5A5F); poll(3);
    wr(8'h38, 16'hFFFF); poll(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule